// File: doc/BRIEF.md
# Programmable-Increment System Time Counter

This block keeps a free-running 64-bit time-of-day value for stamping packets. The counter does not count clock cycles. After every `period` clock cycles it adds a 24-bit fixed-point `step`. Software scales the step left so that its low bits carry fractional nanoseconds, which lets it trim the counter rate in very fine increments. The full counter is always visible on `time_now`.

Software reaches three 32-bit registers through a synchronous read/write strobe port. The time is split into a low word and a high word. The control word packs the period and the step together. A read of the low word freezes the high word in a shadow register, so a low-then-high read pair is never torn. A write to the low word is only staged. The write to the high word that follows commits all 64 bits in one cycle.

A one-cycle flag reports every carry out of bit 63. The counter wraps modulo 2^64. As an example, at 25 MHz with a step of 40 shifted left by 18, the counter wraps after about 19.5 hours.

Top module: `systime_counter`

## Requirements
- R1: After reset, `time_now` is zero, `wrap_pulse` is low, and the control word and the high-word shadow both read as zero.
- R2: The control word is at address 2. Bits 31:24 hold the period in clock cycles and bits 23:0 hold the step. A read of address 2 returns the last value written. Address 3 reads as zero.
- R3: With a nonzero period P written at clock edge E, the counter adds the step at edges E+P, E+2P, and so on, and holds its value between those edges. With P=1 and step 40<<18, ten cycles advance the value shifted right by 18 by 400. With P=3 and step 125<<14, each addition advances the value shifted right by 14 by 125.
- R4: A period of zero stops the counter. `time_now` then holds its value for any step.
- R5: Every write to the control word restarts the cycle prescaler from zero. A tick that would fall in the cycle of that write is cancelled.
- R6: A read of address 0 returns the low 32 bits and latches the high 32 bits into a shadow. A later read of address 1 returns the shadow, even if the counter's high word has changed since.
- R7: A write to address 0 only stages the data and leaves `time_now` unchanged. A write to address 1 loads {write data, staged low} into the counter at that edge.
- R8: A load in the same cycle as an increment takes priority. The loaded value appears exactly, and counting resumes on the next tick.
- R9: Additions wrap modulo 2^64. `wrap_pulse` is high for exactly the one cycle after an addition that carried out of bit 63, and is otherwise low.
- R10: Read data appears on `reg_rdata` at the clock edge that samples `reg_rd`, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 time low, 1 time high, 2 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| time_now | output | 64 | Current counter value |
| wrap_pulse | output | 1 | One-cycle flag after a carry out of bit 63 |

## Verification
The bench builds the block with its default widths: an 8-bit period, a 24-bit step, and therefore a 64-bit counter. With these widths both example rate settings are exercised with their real scaling, and the nanosecond part is recovered by shifting right by 18 or by 14. Because the counter can be loaded through the high-word commit, the bench preloads values just below 2^64 and just below a high-word rollover. This makes the wrap flag and the shadow-read hazard reachable within a few cycles instead of hours.

// File: rtl/systime_pkg.sv
package systime_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_TIME_LO  = 2'd0,
    ADDR_TIME_HI  = 2'd1,
    ADDR_INC_CTRL = 2'd2,
    ADDR_RSVD     = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/systime_prescaler.sv
module systime_prescaler #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);

  logic [PERIOD_W-1:0] cnt_q;
  logic                run;
  logic                last;

  function automatic logic at_end(input logic [PERIOD_W-1:0] c,
                                  input logic [PERIOD_W-1:0] p);
    return (p != '0) && (c == p - 1'b1);
  endfunction

  assign run  = (period != '0);
  assign last = at_end(cnt_q, period);
  assign tick = last && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !run || last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/systime_accum.sv
module systime_accum #(
  parameter int TIME_W = 64,
  parameter int STEP_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] time_q,
  output logic              wrap_q
);

  localparam int PAD_W = TIME_W + 1 - STEP_W;

  logic [TIME_W:0] sum;

  function automatic logic [TIME_W:0] add_step(input logic [TIME_W-1:0] t,
                                               input logic [STEP_W-1:0] s);
    return {1'b0, t} + {{PAD_W{1'b0}}, s};
  endfunction

  assign sum = add_step(time_q, step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
      wrap_q <= 1'b0;
    end else if (load) begin
      time_q <= load_val;
      wrap_q <= 1'b0;
    end else if (tick) begin
      time_q <= sum[TIME_W-1:0];
      wrap_q <= sum[TIME_W];
    end else begin
      wrap_q <= 1'b0;
    end
  end

endmodule

// File: rtl/systime_regif.sv
module systime_regif
  import systime_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int STEP_W   = 24,
  parameter int REG_W    = PERIOD_W + STEP_W,
  parameter int TIME_W   = 2 * REG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic [TIME_W-1:0]   time_now,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [PERIOD_W-1:0] period,
  output logic [STEP_W-1:0]   step,
  output logic                restart,
  output logic                load_en,
  output logic [TIME_W-1:0]   load_val
);

  reg_addr_e        addr;
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] stage_lo_q;
  logic [REG_W-1:0] shadow_hi_q;
  logic             wr_lo;

  assign addr     = reg_addr_e'(reg_addr);
  assign period   = ctrl_q[REG_W-1 -: PERIOD_W];
  assign step     = ctrl_q[STEP_W-1:0];
  assign restart  = reg_wr && (addr == ADDR_INC_CTRL);
  assign load_en  = reg_wr && (addr == ADDR_TIME_HI);
  assign wr_lo    = reg_wr && (addr == ADDR_TIME_LO);
  assign load_val = {reg_wdata, stage_lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      stage_lo_q <= '0;
    end else begin
      if (restart) ctrl_q <= reg_wdata;
      if (wr_lo)   stage_lo_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata   <= '0;
      shadow_hi_q <= '0;
    end else if (reg_rd) begin
      unique case (addr)
        ADDR_TIME_LO: begin
          reg_rdata   <= time_now[REG_W-1:0];
          shadow_hi_q <= time_now[TIME_W-1:REG_W];
        end
        ADDR_TIME_HI:  reg_rdata <= shadow_hi_q;
        ADDR_INC_CTRL: reg_rdata <= ctrl_q;
        default:       reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/systime_counter.sv
module systime_counter
  import systime_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int STEP_W   = 24
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               reg_wr,
  input  logic                               reg_rd,
  input  logic [1:0]                         reg_addr,
  input  logic [PERIOD_W+STEP_W-1:0]         reg_wdata,
  output logic [PERIOD_W+STEP_W-1:0]         reg_rdata,
  output logic [2*(PERIOD_W+STEP_W)-1:0]     time_now,
  output logic                               wrap_pulse
);

  localparam int REG_W  = PERIOD_W + STEP_W;
  localparam int TIME_W = 2 * REG_W;

  logic [PERIOD_W-1:0] period;
  logic [STEP_W-1:0]   step;
  logic                restart;
  logic                tick;
  logic                load_en;
  logic [TIME_W-1:0]   load_val;

  systime_regif #(
    .PERIOD_W(PERIOD_W), .STEP_W(STEP_W), .REG_W(REG_W), .TIME_W(TIME_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .time_now(time_now),
    .reg_rdata(reg_rdata), .period(period), .step(step),
    .restart(restart), .load_en(load_en), .load_val(load_val)
  );

  systime_prescaler #(.PERIOD_W(PERIOD_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(restart), .period(period), .tick(tick)
  );

  systime_accum #(.TIME_W(TIME_W), .STEP_W(STEP_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step), .load(load_en),
    .load_val(load_val), .time_q(time_now), .wrap_q(wrap_pulse)
  );

endmodule

// File: rtl/systime_checker.sv
module systime_checker #(
  parameter int PERIOD_W = 8,
  parameter int STEP_W   = 24,
  parameter int TIME_W   = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                restart,
  input logic [PERIOD_W-1:0] period,
  input logic [STEP_W-1:0]   step,
  input logic                load_en,
  input logic [TIME_W-1:0]   load_val,
  input logic [TIME_W-1:0]   time_now,
  input logic                wrap_pulse
);

  // R4: a zero period never produces a tick
  a_r4_no_tick_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> !tick);

  // R3: no change between ticks
  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_en) |=> $stable(time_now));

  // R3: each tick adds the step
  a_r3_step_added: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_en) |=> (time_now == TIME_W'($past(time_now) + TIME_W'($past(step)))));

  // R5: restart pushes the next tick out
  a_r5_restart_delays: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (period == 1 || !tick));

  // R8: load wins over increment
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (time_now == $past(load_val)) && !wrap_pulse);

  // R9: wrap flag lasts one cycle
  a_r9_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);

  // R9: wrap flag only follows a carrying addition
  a_r9_wrap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> $past(tick) && (time_now < $past(time_now)));

endmodule

bind systime_counter systime_checker #(
  .PERIOD_W(PERIOD_W), .STEP_W(STEP_W), .TIME_W(TIME_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart), .period(period),
  .step(step), .load_en(load_en), .load_val(load_val), .time_now(time_now),
  .wrap_pulse(wrap_pulse)
);

// File: tb/tb_systime_counter.sv
module tb_systime_counter;
  import systime_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_now;
  logic        wrap_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  systime_counter dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_now(time_now), .wrap_pulse(wrap_pulse)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_ctrl(input logic [7:0] p, input logic [23:0] s);
    wr(ADDR_INC_CTRL, {p, s});
  endtask

  task automatic load_time(input logic [63:0] t);
    wr(ADDR_TIME_LO, t[31:0]);
    wr(ADDR_TIME_HI, t[63:32]);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 time", time_now, 64'd0);
    check("R1 wrap", {63'd0, wrap_pulse}, 64'd0);
    rd(ADDR_INC_CTRL, d); check("R1 ctrl", {32'd0, d}, 64'd0);
    rd(ADDR_TIME_HI, d);  check("R1 shadow", {32'd0, d}, 64'd0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    set_ctrl(8'h03, 24'h1F4000);
    rd(ADDR_INC_CTRL, d); check("R2 ctrl readback", {32'd0, d}, 64'h031F4000);
    rd(ADDR_RSVD, d);     check("R2 reserved", {32'd0, d}, 64'd0);
    cyc(3);
    check("R10 rdata held", {32'd0, reg_rdata}, 64'd0);
    set_ctrl(8'h00, 24'h0);
    load_time(64'd0);
  endtask

  task automatic t_period3;
    logic [63:0] s = 64'h1F4000;
    set_ctrl(8'd3, 24'h1F4000);
    check("R3 p3 e0", time_now, 64'd0);
    cyc(2); check("R3 p3 e2", time_now, 64'd0);
    cyc(1); check("R3 p3 e3", time_now, s);
    cyc(3); check("R3 p3 e6", time_now, 2 * s);
    cyc(30); check("R3 p3 e36", time_now, 12 * s);
    check("R3 p3 ns", time_now >> 14, 64'd1500);
    set_ctrl(8'd0, 24'd0);
  endtask

  task automatic t_rate25;
    load_time(64'd0);
    set_ctrl(8'd1, 24'(40 << 18));
    cyc(10);
    check("R3 25MHz raw", time_now, 64'd10 * 64'hA00000);
    check("R3 25MHz ns", time_now >> 18, 64'd400);
    set_ctrl(8'd0, 24'd0);
  endtask

  task automatic t_halt;
    load_time(64'h1234);
    set_ctrl(8'd0, 24'hFFFFFF);
    cyc(20);
    check("R4 halted", time_now, 64'h1234);
    check("R4 no wrap", {63'd0, wrap_pulse}, 64'd0);
  endtask

  task automatic t_restart;
    set_ctrl(8'd0, 24'd0);
    load_time(64'd0);
    set_ctrl(8'd4, 24'd1);
    cyc(2);
    set_ctrl(8'd4, 24'd1);
    check("R5 after rewrite", time_now, 64'd0);
    cyc(3); check("R5 old tick cancelled", time_now, 64'd0);
    cyc(1); check("R5 new tick", time_now, 64'd1);
    set_ctrl(8'd0, 24'd0);
  endtask

  task automatic t_shadow;
    logic [31:0] d;
    load_time(64'h5_FFFFFF00);
    set_ctrl(8'd1, 24'h000100);
    rd(ADDR_TIME_LO, d);
    check("R6 low word", {32'd0, d}, 64'hFFFFFF00);
    check("R6 live high moved", {32'd0, time_now[63:32]}, 64'd6);
    rd(ADDR_TIME_HI, d);
    check("R6 shadow high", {32'd0, d}, 64'd5);
    set_ctrl(8'd0, 24'd0);
  endtask

  task automatic t_stage;
    load_time(64'hAAAA);
    wr(ADDR_TIME_LO, 32'h1111_2222);
    check("R7 staged only", time_now, 64'hAAAA);
    wr(ADDR_TIME_HI, 32'h3333_4444);
    check("R7 committed", time_now, 64'h3333_4444_1111_2222);
  endtask

  task automatic t_priority;
    set_ctrl(8'd1, 24'd1);
    cyc(2);
    load_time(64'h20_0000_0010);
    check("R8 load exact", time_now, 64'h20_0000_0010);
    cyc(1); check("R8 resumes", time_now, 64'h20_0000_0011);
    set_ctrl(8'd0, 24'd0);
  endtask

  task automatic t_wrap;
    load_time(64'hFFFF_FFFF_FFFF_FFFE);
    set_ctrl(8'd1, 24'd5);
    check("R9 before", time_now, 64'hFFFF_FFFF_FFFF_FFFE);
    check("R9 no flag yet", {63'd0, wrap_pulse}, 64'd0);
    cyc(1);
    check("R9 wrapped", time_now, 64'd3);
    check("R9 flag", {63'd0, wrap_pulse}, 64'd1);
    cyc(1);
    check("R9 next", time_now, 64'd8);
    check("R9 flag drops", {63'd0, wrap_pulse}, 64'd0);
    set_ctrl(8'd0, 24'd0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_fields();
    t_period3();
    t_rate25();
    t_halt();
    t_restart();
    t_shadow();
    t_stage();
    t_priority();
    t_wrap();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule